// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block sits between five interrupt request sources of a small 8-bit microcontroller core and the core's interrupt entry logic. The five sources are two external request lines, two timer overflow flags and one serial flag, which is the OR of receive and transmit. Software programs two registers. The mask register has one enable bit for each source and a master enable bit. The level register gives each source a low or a high level. Every cycle the block decides whether to request an interrupt from the core, and which source number to report.

Inside each level the sources are polled in a fixed order. Any high-level request outranks every low-level request. The block keeps one in-service flag for each level. The core's acknowledge sets the flag for the level of the source it takes, and a return-from-interrupt pulse clears the innermost level. So a high-level request can only preempt a low-level handler, and a request never interrupts a handler of its own level or of a higher level.

The request inputs are levels held by the peripherals. The block does not clear them itself. When the core accepts a source, the block returns a one-cycle strobe on that source's line so the peripheral can drop its flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset both registers are zero, so every source is masked and at low level. `irq_req_o`, `src_ack_o`, `isr_hi_o` and `isr_lo_o` are all 0.
- R2: A cycle with `en_we_i` high loads the mask register from `wdata_i`. Bit 7 is the master enable and bits 0 to 4 enable sources 0 to 4. Bits 5 and 6 have no effect. The new value acts from the next cycle.
- R3: While the master enable bit is 0, `irq_req_o` stays low whatever the source enables and requests are.
- R4: A source whose own enable bit is 0 never wins, even when it is requesting.
- R5: A cycle with `pri_we_i` high loads the level register from `wdata_i` bits 0 to 4. A 1 puts that source at high level and a 0 puts it at low level. The new value acts from the next cycle.
- R6: Source indices are external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4. Among eligible requests at the same level the lowest index wins, and `irq_idx_o` reports that index.
- R7: When eligible requests exist at both levels, the high-level request with the lowest index wins, whatever the indices of the low-level requests.
- R8: When `ack_i` is high while `irq_req_o` is high, `src_ack_o` is one-hot on the reported source in that same cycle. From the next cycle the in-service flag of that source's level is set (`isr_hi_o` for high, `isr_lo_o` for low).
- R9: While `isr_lo_o` is set no low-level request is raised. While `isr_hi_o` is set no request of either level is raised.
- R10: While only `isr_lo_o` is set, an eligible high-level request raises `irq_req_o` and reports its index.
- R11: A cycle with `reti_i` high clears `isr_hi_o` if it is set. Otherwise it clears `isr_lo_o`.
- R12: `ack_i` while `irq_req_o` is low changes no in-service flag and gives an all-zero `src_ack_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_we_i | input | 1 | Write strobe for the mask register |
| pri_we_i | input | 1 | Write strobe for the level register |
| wdata_i | input | 8 | Register write data |
| src_req_i | input | 5 | Pending request level, one bit per source |
| ack_i | input | 1 | One-cycle acknowledge from the core |
| reti_i | input | 1 | One-cycle return-from-interrupt pulse |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_idx_o | output | 3 | Index of the winning source (0 when no request) |
| src_ack_o | output | 5 | One-cycle per-source acknowledge strobe |
| isr_hi_o | output | 1 | High-level handler in service |
| isr_lo_o | output | 1 | Low-level handler in service |

## Verification
The bench builds the block with its default parameters: five sources, an 8-bit register width and the master bit at bit 7. With these values every poll position, including the serial source at the bottom of the order, can be reached both as a winner and as a loser. The unused register bits 5 and 6 can also be written, so the bench can show that they have no effect. Because there are only two levels, short directed sequences reach every combination of in-service flags: low-handler preemption, same-level blocking, low requests blocked under a high handler, and acknowledge or return pulses applied at each nesting depth.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } irq_lvl_e;

   localparam int unsigned NUM_LVL = 2;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned REG_W   = 8,
   parameter int unsigned GLB_BIT = 7
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_we_i,
   input  logic               pri_we_i,
   input  logic [REG_W-1:0]   wdata_i,
   output logic [NUM_SRC-1:0] src_en_o,
   output logic [NUM_SRC-1:0] src_pri_o,
   output logic               glb_en_o
);
   localparam logic [REG_W-1:0] SRC_MASK  = REG_W'((64'd1 << NUM_SRC) - 64'd1);
   localparam logic [REG_W-1:0] USED_MASK = SRC_MASK | (REG_W'(1) << GLB_BIT);

   if (NUM_SRC < 1) begin : g_chk_src
      $error("irq_cfg_regs: NUM_SRC must be at least 1");
   end
   if (GLB_BIT >= REG_W) begin : g_chk_glb
      $error("irq_cfg_regs: GLB_BIT lies outside the register");
   end
   if (NUM_SRC > GLB_BIT) begin : g_chk_overlap
      $error("irq_cfg_regs: source bits overlap the master bit");
   end

   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] pri_q;
   logic               glb_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= '0;
         glb_q <= 1'b0;
      end else if (en_we_i) begin
         en_q  <= wdata_i[NUM_SRC-1:0];
         glb_q <= wdata_i[GLB_BIT];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pri_q <= '0;
      end else if (pri_we_i) begin
         pri_q <= wdata_i[NUM_SRC-1:0];
      end
   end

   logic unused_wbits;
   assign unused_wbits = ^(wdata_i & ~USED_MASK);

   assign src_en_o  = en_q;
   assign src_pri_o = pri_q;
   assign glb_en_o  = glb_q;
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned IDX_W   = 3
) (
   input  logic [NUM_SRC-1:0] vec_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic [NUM_SRC-1:0] onehot_o
);
   if ((64'd1 << IDX_W) < NUM_SRC) begin : g_chk_idx
      $error("irq_level_pick: IDX_W too narrow for NUM_SRC");
   end

   // seen[i] is set when some source below i is pending
   logic [NUM_SRC:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
      assign seen[i+1]   = seen[i] | vec_i[i];
      assign onehot_o[i] = vec_i[i] & ~seen[i];
   end

   assign any_o = seen[NUM_SRC];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track
   import irq_arb_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     take_i,
   input  irq_lvl_e take_lvl_i,
   input  logic     reti_i,
   output logic     isr_hi_o,
   output logic     isr_lo_o
);
   logic hi_q, lo_q;
   logic hi_d, lo_d;

   always_comb begin
      hi_d = (hi_q & ~reti_i) | (take_i & (take_lvl_i == LVL_HIGH));
      lo_d = (lo_q & ~(reti_i & ~hi_q)) | (take_i & (take_lvl_i == LVL_LOW));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= hi_d;
         lo_q <= lo_d;
      end
   end

   assign isr_hi_o = hi_q;
   assign isr_lo_o = lo_q;

   AST_TAKE_HI_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && take_lvl_i == LVL_HIGH) |=> isr_hi_o); // R8
   AST_TAKE_LO_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && take_lvl_i == LVL_LOW) |=> isr_lo_o); // R8
   AST_RETI_POPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reti_i && isr_hi_o && !(take_i && take_lvl_i == LVL_HIGH)) |=> (!isr_hi_o && $stable(isr_lo_o))); // R11
   AST_RETI_POPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reti_i && !isr_hi_o && !take_i) |=> !isr_lo_o); // R11
   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!take_i && !reti_i) |=> ($stable(isr_hi_o) && $stable(isr_lo_o))); // R12
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irq_arb_pkg::*;
#(
   parameter  int unsigned NUM_SRC = 5,
   parameter  int unsigned REG_W   = 8,
   parameter  int unsigned GLB_BIT = 7,
   localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_we_i,
   input  logic               pri_we_i,
   input  logic [REG_W-1:0]   wdata_i,
   input  logic [NUM_SRC-1:0] src_req_i,
   input  logic               ack_i,
   input  logic               reti_i,
   output logic               irq_req_o,
   output logic [IDX_W-1:0]   irq_idx_o,
   output logic [NUM_SRC-1:0] src_ack_o,
   output logic               isr_hi_o,
   output logic               isr_lo_o
);
   logic [NUM_SRC-1:0] src_en, src_pri;
   logic               glb_en;

   irq_cfg_regs #(
      .NUM_SRC (NUM_SRC),
      .REG_W   (REG_W),
      .GLB_BIT (GLB_BIT)
   ) i_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_we_i   (en_we_i),
      .pri_we_i  (pri_we_i),
      .wdata_i   (wdata_i),
      .src_en_o  (src_en),
      .src_pri_o (src_pri),
      .glb_en_o  (glb_en)
   );

   logic [NUM_SRC-1:0] eligible;
   assign eligible = src_req_i & src_en & {NUM_SRC{glb_en}};

   logic [NUM_SRC-1:0] lvl_vec    [NUM_LVL];
   logic [NUM_SRC-1:0] lvl_onehot [NUM_LVL];
   logic [IDX_W-1:0]   lvl_idx    [NUM_LVL];
   logic [NUM_LVL-1:0] lvl_any;

   for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
      if (lv == int'(LVL_HIGH)) begin : g_hi
         assign lvl_vec[lv] = eligible & src_pri;
      end else begin : g_lo
         assign lvl_vec[lv] = eligible & ~src_pri;
      end
      irq_level_pick #(
         .NUM_SRC (NUM_SRC),
         .IDX_W   (IDX_W)
      ) i_pick (
         .vec_i    (lvl_vec[lv]),
         .any_o    (lvl_any[lv]),
         .idx_o    (lvl_idx[lv]),
         .onehot_o (lvl_onehot[lv])
      );
   end

   logic     isr_hi, isr_lo;
   logic     hi_ok, lo_ok, take;
   irq_lvl_e win_lvl;

   always_comb begin
      hi_ok   = lvl_any[LVL_HIGH] & ~isr_hi;
      lo_ok   = lvl_any[LVL_LOW] & ~isr_hi & ~isr_lo;
      win_lvl = hi_ok ? LVL_HIGH : LVL_LOW;
      take    = ack_i & (hi_ok | lo_ok);
   end

   irq_nest_track i_nest (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .take_i     (take),
      .take_lvl_i (win_lvl),
      .reti_i     (reti_i),
      .isr_hi_o   (isr_hi),
      .isr_lo_o   (isr_lo)
   );

   assign irq_req_o = hi_ok | lo_ok;
   assign irq_idx_o = hi_ok ? lvl_idx[LVL_HIGH] : (lo_ok ? lvl_idx[LVL_LOW] : '0);
   assign src_ack_o = take ? lvl_onehot[win_lvl] : '0;
   assign isr_hi_o  = isr_hi;
   assign isr_lo_o  = isr_lo;

   AST_MASTER_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !glb_en |-> !irq_req_o); // R3
   AST_WINNER_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_req_o |-> (src_req_i[irq_idx_o] && src_en[irq_idx_o])); // R4
   AST_HI_BLOCKS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      isr_hi_o |-> !irq_req_o); // R9
   AST_LO_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_req_o && isr_lo_o) |-> src_pri[irq_idx_o]); // R10
   AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(src_ack_o)); // R8
   AST_ACK_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_ack_o != '0) |-> (ack_i && irq_req_o && src_ack_o[irq_idx_o])); // R12
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       en_we = 1'b0, pri_we = 1'b0, ack = 1'b0, reti = 1'b0;
   logic [7:0] wdata = '0;
   logic [4:0] req = '0;
   logic       irq_req;
   logic [2:0] irq_idx;
   logic [4:0] src_ack;
   logic       isr_hi, isr_lo;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 1'b0;
   string phase   = "R1";

   always #10 clk = ~clk;

   prio_irq_ctrl i_prio_irq_ctrl (
      .clk_i     (clk),
      .rst_ni    (rst_ni),
      .en_we_i   (en_we),
      .pri_we_i  (pri_we),
      .wdata_i   (wdata),
      .src_req_i (req),
      .ack_i     (ack),
      .reti_i    (reti),
      .irq_req_o (irq_req),
      .irq_idx_o (irq_idx),
      .src_ack_o (src_ack),
      .isr_hi_o  (isr_hi),
      .isr_lo_o  (isr_lo)
   );

   // ---------------- behavioural reference model ----------------
   bit [7:0] m_en;
   bit [4:0] m_pri;
   bit       m_hi, m_lo;

   function automatic int model_winner(output bit is_high);
      int best_hi = -1;
      int best_lo = -1;
      is_high = 1'b0;
      if (!m_en[7]) return -1;
      for (int s = 4; s >= 0; s--) begin
         if (req[s] && m_en[s]) begin
            if (m_pri[s]) best_hi = s;
            else          best_lo = s;
         end
      end
      if (best_hi >= 0 && !m_hi) begin
         is_high = 1'b1;
         return best_hi;
      end
      if (best_lo >= 0 && !m_hi && !m_lo) return best_lo;
      return -1;
   endfunction

   always @(posedge clk) begin
      if (!rst_ni) begin
         m_en = '0; m_pri = '0; m_hi = 1'b0; m_lo = 1'b0;
      end else begin
         bit lvl;
         int w;
         bit nh, nl;
         w  = model_winner(lvl);
         nh = m_hi; nl = m_lo;
         if (reti) begin
            if (m_hi) nh = 1'b0;
            else      nl = 1'b0;
         end
         if (ack && w >= 0) begin
            if (lvl) nh = 1'b1;
            else     nl = 1'b1;
         end
         m_hi = nh; m_lo = nl;
         if (en_we)  m_en  = wdata;
         if (pri_we) m_pri = wdata[4:0];
      end
   end

   task automatic check(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_ni && !done) begin
         bit lvl;
         int w;
         logic [4:0] exp_ack;
         w = model_winner(lvl);
         exp_ack = (ack && w >= 0) ? 5'(1 << w) : 5'd0;
         check({phase, " model req"}, int'(irq_req), int'(w >= 0));
         check({phase, " model idx"}, int'(irq_idx), (w >= 0) ? w : 0);
         check({phase, " model src_ack"}, int'(src_ack), int'(exp_ack));
         check({phase, " model isr_hi"}, int'(isr_hi), int'(m_hi));
         check({phase, " model isr_lo"}, int'(isr_lo), int'(m_lo));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_mask(logic [7:0] v);
      tick(); en_we = 1'b1; wdata = v;
      tick(); en_we = 1'b0; wdata = '0;
   endtask

   task automatic wr_lvl(logic [7:0] v);
      tick(); pri_we = 1'b1; wdata = v;
      tick(); pri_we = 1'b0; wdata = '0;
   endtask

   task automatic set_req(logic [4:0] v);
      tick(); req = v;
   endtask

   task automatic expect_out(string tag, bit exp_req, int exp_idx);
      @(negedge clk);
      check({tag, " irq_req"}, int'(irq_req), int'(exp_req));
      if (exp_req) check({tag, " irq_idx"}, int'(irq_idx), exp_idx);
   endtask

   task automatic expect_isr(string tag, bit exp_hi, bit exp_lo);
      @(negedge clk);
      check({tag, " isr_hi"}, int'(isr_hi), int'(exp_hi));
      check({tag, " isr_lo"}, int'(isr_lo), int'(exp_lo));
   endtask

   task automatic pulse_ack(string tag, logic [4:0] exp_strobe);
      tick(); ack = 1'b1;
      @(negedge clk);
      check({tag, " src_ack"}, int'(src_ack), int'(exp_strobe));
      tick(); ack = 1'b0;
   endtask

   task automatic pulse_reti();
      tick(); reti = 1'b1;
      tick(); reti = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (400) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_ni = 1'b1;

      phase = "R1";
      expect_out("R1 reset", 1'b0, 0);
      expect_isr("R1 reset", 1'b0, 1'b0);
      check("R1 reset src_ack", int'(src_ack), 0);
      set_req(5'h1F);
      expect_out("R1 masked after reset", 1'b0, 0);

      phase = "R3";
      wr_mask(8'h1F);
      expect_out("R3 master off", 1'b0, 0);

      phase = "R6";
      wr_mask(8'h9F);
      expect_out("R6 all low, ext0 first", 1'b1, 0);
      set_req(5'b11110); expect_out("R6 timer0", 1'b1, 1);
      set_req(5'b11100); expect_out("R6 ext1", 1'b1, 2);
      set_req(5'b11000); expect_out("R6 timer1", 1'b1, 3);
      set_req(5'b10000); expect_out("R6 serial last", 1'b1, 4);

      phase = "R4";
      set_req(5'h1F);
      wr_mask(8'h9C);
      expect_out("R4 sources 0,1 masked", 1'b1, 2);
      wr_mask(8'h80);
      expect_out("R4 all sources masked", 1'b0, 0);

      phase = "R2";
      wr_mask(8'hE1);
      set_req(5'b11110);
      expect_out("R2 bits 5,6 no effect", 1'b0, 0);
      set_req(5'b00001);
      expect_out("R2 src0 enabled", 1'b1, 0);

      phase = "R7";
      set_req(5'h1F);
      wr_mask(8'h9F);
      wr_lvl(8'h08);
      expect_out("R7 high timer1 beats low", 1'b1, 3);
      phase = "R5";
      wr_lvl(8'h14);
      expect_out("R5 highs 2,4: ext1 wins", 1'b1, 2);
      wr_lvl(8'h00);
      expect_out("R5 all low again", 1'b1, 0);

      phase = "R8";
      wr_lvl(8'h10);
      set_req(5'b00001);
      expect_out("R8 low ext0 raised", 1'b1, 0);
      pulse_ack("R8 ack ext0", 5'b00001);
      expect_isr("R8 low in service", 1'b0, 1'b1);

      phase = "R9";
      expect_out("R9 same source blocked", 1'b0, 0);
      set_req(5'b00011);
      expect_out("R9 other low blocked", 1'b0, 0);

      phase = "R10";
      set_req(5'b10011);
      expect_out("R10 high serial preempts", 1'b1, 4);
      pulse_ack("R10 ack serial", 5'b10000);
      expect_isr("R10 both in service", 1'b1, 1'b1);

      phase = "R9";
      expect_out("R9 high handler blocks all", 1'b0, 0);

      phase = "R11";
      pulse_reti();
      expect_isr("R11 reti pops high", 1'b0, 1'b1);
      expect_out("R11 high serial again", 1'b1, 4);
      set_req(5'b00011);
      expect_out("R11 low still blocked", 1'b0, 0);
      pulse_reti();
      expect_isr("R11 reti pops low", 1'b0, 1'b0);
      expect_out("R11 low ext0 now taken", 1'b1, 0);

      phase = "R9";
      wr_lvl(8'h01);
      pulse_ack("R9 ack high ext0", 5'b00001);
      expect_isr("R9 high in service", 1'b1, 1'b0);
      set_req(5'b00010);
      expect_out("R9 low blocked under high", 1'b0, 0);
      pulse_reti();

      phase = "R12";
      set_req(5'b00000);
      pulse_ack("R12 ack without request", 5'b00000);
      expect_isr("R12 flags unchanged", 1'b0, 1'b0);

      phase = "R3";
      set_req(5'h1F);
      wr_mask(8'h1F);
      expect_out("R3 master cleared", 1'b0, 0);

      tick();
      finish_run();
   end
endmodule